// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a small byte-addressed serial EEPROM that sits on a two-wire bus. It oversamples the clock and data lines with the system clock and detects START and STOP conditions. It checks the device-select byte and keeps one internal address counter. The storage array, a 256-byte synchronous register file, sits inside the block. The block drives the data line only as an open-drain pull-down enable.

A write transfer sends the device-select byte with the direction bit at 0, then one address byte, then one or more data bytes. The data bytes go into a 16-byte staging buffer and are written to the array when the master ends the transfer with STOP. A write-control input turns away data bytes while it is high. A read transfer streams bytes from the counter for as long as the master acknowledges each one. A repeated START after the address byte turns a write header into a read from the address just loaded.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, and in the cycles after every STOP, `sda_drive_low` is 0.
- R2: A device-select byte is acknowledged only when its upper 7 bits equal `DEV_CODE` (default 7'b1010000). Bit 0 is the direction bit: 0 means write, 1 means read. A non-matching select is not acknowledged, and the bytes that follow it up to the next START are ignored, with no effect on the memory or the counter.
- R3: The first byte after a write select is always acknowledged and is loaded into the address counter.
- R4: With `wc` low, every data byte of a write is acknowledged. Once STOP arrives, each byte sits in the array at the address it was received on, the first at the loaded address.
- R5: During a write, only the low 4 address bits advance after each data byte, so a write past the end of a 16-byte page continues at the start of that same page.
- R6: While `wc` is high, data bytes are not acknowledged and the array content is left unchanged. The address counter keeps the loaded address.
- R7: A read select with no address byte before it (current-address read) starts at the counter value, which is one past the last byte read or written.
- R8: An address byte followed by a repeated START and a read select reads from the address just loaded.
- R9: While the master acknowledges, read bytes continue at consecutive addresses, wrapping from 255 to 0.
- R10: If the master leaves the data line high in the ninth bit of a read byte, the slave stops driving and ignores clock pulses until the next START. The counter still advances past that byte.
- R11: Read data is sent most significant bit first. `sda_drive_low` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired level) |
| wc | input | 1 | Write control: 1 blocks data bytes from the memory |
| sda_drive_low | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The array is first filled through full 16-byte page writes. After that come directed transfers for the corner cases: a read run that crosses from 255 to 0, a write that runs off the end of a page, a select with the wrong code, a write with `wc` high, and a read that the master ends early with a NACK. The page-wrap case separates page-local addressing from a flat counter. The NACK case checks both that the slave releases the line during the following clock pulses and that the counter still moved. A seeded random mix of writes (varying address, length and `wc`) and of current-address and random-address reads then runs against a byte model of the array and the counter. Every acknowledge bit and every data byte returned is compared with that model.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } ctrl_st_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
      scl_p  <= scl_sh[SYNC_STAGES-1];
      sda_p  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eeprom_mem_array.sv
module eeprom_mem_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_page_buffer.sv
module eeprom_page_buffer #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [PB-1:0]    wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             commit,
  input  logic [AW-PB-1:0] base,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [DW-1:0]    mem_wdata,
  output logic             busy
);
  localparam int PAGE = 1 << PB;
  localparam logic [PB-1:0] IDX_ONE  = {{(PB-1){1'b0}}, 1'b1};
  localparam logic [PB-1:0] IDX_LAST = {PB{1'b1}};

  logic [DW-1:0]    data_q [PAGE];
  logic [PAGE-1:0]  valid_q, valid_n;
  logic             busy_q, busy_n;
  logic [PB-1:0]    idx_q, idx_n;
  logic [AW-PB-1:0] base_q, base_n;

  always_comb begin
    valid_n = valid_q;
    busy_n  = busy_q;
    idx_n   = idx_q;
    base_n  = base_q;
    if (busy_q) begin
      valid_n[idx_q] = 1'b0;
      idx_n          = idx_q + IDX_ONE;
      if (idx_q == IDX_LAST) busy_n = 1'b0;
    end else begin
      if (clear) valid_n = '0;
      if (commit && (|valid_q)) begin
        busy_n = 1'b1;
        idx_n  = '0;
        base_n = base;
      end
    end
    if (wr_en) valid_n[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      base_q  <= '0;
    end else begin
      valid_q <= valid_n;
      busy_q  <= busy_n;
      idx_q   <= idx_n;
      base_q  <= base_n;
    end
  end

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == g[PB-1:0])) data_q[g] <= wr_data;
    end
  end

  assign mem_we    = busy_q & valid_q[idx_q];
  assign mem_waddr = {base_q, idx_q};
  assign mem_wdata = data_q[idx_q];
  assign busy      = busy_q;
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         PAGE_BITS = 4,
  parameter logic [6:0] DEV_CODE  = 7'b1010000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wc,
  output logic sda_drive_low
);
  localparam int AW = ADDR_W;
  localparam int PB = PAGE_BITS;
  localparam logic [AW-1:0] ADDR_ONE = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [PB-1:0] PG_ONE   = {{(PB-1){1'b0}}, 1'b1};
  localparam logic [3:0]    ACK_SLOT = 4'd8;

  logic [1:0] rs_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sampler #(.SYNC_STAGES(2)) u_line (
    .clk(clk), .rst_n(rst_ns), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ctrl_st_t          st_q, st_n;
  logic [3:0]        bitcnt_q, bitcnt_n;
  logic [BYTE_W-1:0] shreg_q, shreg_n;
  logic [AW-1:0]     addr_q, addr_n;
  logic              ack_q, ack_n;
  logic              drv_q, drv_n;
  logic              buf_clear, buf_wr, buf_commit;
  logic [BYTE_W-1:0] rd_data;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr;
  logic [BYTE_W-1:0] mem_wdata;
  logic              buf_busy;

  always_comb begin
    st_n       = st_q;
    bitcnt_n   = bitcnt_q;
    shreg_n    = shreg_q;
    addr_n     = addr_q;
    ack_n      = ack_q;
    drv_n      = drv_q;
    buf_clear  = 1'b0;
    buf_wr     = 1'b0;
    buf_commit = 1'b0;
    if (stop_det) begin
      st_n       = ST_IDLE;
      drv_n      = 1'b0;
      buf_commit = 1'b1;
    end else if (start_det) begin
      st_n      = ST_DEV;
      bitcnt_n  = '0;
      drv_n     = 1'b0;
      buf_clear = 1'b1;
    end else if (scl_rise) begin
      unique case (st_q)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (bitcnt_q != ACK_SLOT) begin
            shreg_n  = {shreg_q[BYTE_W-2:0], sda_s};
            bitcnt_n = bitcnt_q + 4'd1;
          end else begin
            bitcnt_n = '0;
            if (st_q == ST_DEV) begin
              if (!ack_q)          st_n = ST_IDLE;
              else if (shreg_q[0]) st_n = ST_RDATA;
              else                 st_n = ST_ADDR;
            end else if (st_q == ST_ADDR) begin
              addr_n = shreg_q[AW-1:0];
              st_n   = ST_WDATA;
            end else if (ack_q) begin
              buf_wr = 1'b1;
              addr_n = {addr_q[AW-1:PB], addr_q[PB-1:0] + PG_ONE};
            end
          end
        end
        ST_RDATA: begin
          if (bitcnt_q != ACK_SLOT) begin
            bitcnt_n = bitcnt_q + 4'd1;
          end else begin
            bitcnt_n = '0;
            addr_n   = addr_q + ADDR_ONE;
            if (sda_s) st_n = ST_IDLE;
          end
        end
        default: ;
      endcase
    end else if (scl_fall) begin
      unique case (st_q)
        ST_DEV: begin
          if (bitcnt_q == ACK_SLOT) begin
            ack_n = (shreg_q[BYTE_W-1:1] == DEV_CODE);
            drv_n = ack_n;
          end else begin
            drv_n = 1'b0;
          end
        end
        ST_ADDR: begin
          ack_n = 1'b1;
          drv_n = (bitcnt_q == ACK_SLOT);
        end
        ST_WDATA: begin
          if (bitcnt_q == ACK_SLOT) begin
            ack_n = ~wc;
            drv_n = ~wc;
          end else begin
            drv_n = 1'b0;
          end
        end
        ST_RDATA: begin
          if (bitcnt_q != ACK_SLOT) drv_n = ~rd_data[3'd7 - bitcnt_q[2:0]];
          else                      drv_n = 1'b0;
        end
        default: drv_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q     <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      addr_q   <= '0;
      ack_q    <= 1'b0;
      drv_q    <= 1'b0;
    end else begin
      st_q     <= st_n;
      bitcnt_q <= bitcnt_n;
      shreg_q  <= shreg_n;
      addr_q   <= addr_n;
      ack_q    <= ack_n;
      drv_q    <= drv_n;
    end
  end

  eeprom_page_buffer #(.AW(AW), .DW(BYTE_W), .PB(PB)) u_pbuf (
    .clk(clk), .rst_n(rst_ns), .clear(buf_clear), .wr_en(buf_wr),
    .wr_idx(addr_q[PB-1:0]), .wr_data(shreg_q), .commit(buf_commit),
    .base(addr_q[AW-1:PB]), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .busy(buf_busy)
  );

  eeprom_mem_array #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk(clk), .rst_n(rst_ns), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(addr_q), .rdata(rd_data)
  );

  assign sda_drive_low = drv_q;
endmodule

// File: rtl/eeprom_i2c_checker.sv
module eeprom_i2c_checker
  import eeprom_pkg::*;
#(
  parameter int         AW       = 8,
  parameter int         PB       = 4,
  parameter logic [6:0] DEV_CODE = 7'b1010000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_drive_low,
  input logic          wc,
  input logic          scl_s,
  input logic          sda_s,
  input logic          scl_rise,
  input logic          scl_fall,
  input logic          stop_det,
  input ctrl_st_t      st,
  input logic [3:0]    bitcnt,
  input logic [7:0]    shreg,
  input logic [AW-1:0] addr,
  input logic          buf_busy
);
  a_r11_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_s);

  a_r1_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_drive_low);

  a_r6_wc_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WDATA && scl_fall && bitcnt == 4'd8 && wc) |=> !sda_drive_low);

  a_r2_foreign_select_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEV && scl_fall && bitcnt == 4'd8 && shreg[7:1] != DEV_CODE)
      |=> !sda_drive_low);

  a_r10_nack_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RDATA && scl_rise && bitcnt == 4'd8 && sda_s) |=> st == ST_IDLE);

  a_r5_page_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WDATA && $past(st) == ST_WDATA && !buf_busy)
      |-> addr[AW-1:PB] == $past(addr[AW-1:PB]));
endmodule

bind eeprom_i2c_slave eeprom_i2c_checker #(
  .AW(ADDR_W), .PB(PAGE_BITS), .DEV_CODE(DEV_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_ns), .sda_drive_low(sda_drive_low), .wc(wc),
  .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .stop_det(stop_det), .st(st_q), .bitcnt(bitcnt_q), .shreg(shreg_q),
  .addr(addr_q), .buf_busy(buf_busy)
);

// File: tb/eeprom_i2c_slave_tb_top.sv
module eeprom_i2c_slave_tb_top;
  localparam logic [6:0] DEV = 7'b1010000;
  localparam int W = 5;

  logic clk, rst_n, scl_m, m_low, wc, dut_low;
  wire  sda_line = ~(m_low | dut_low);

  int n_cmp, n_err;
  logic [7:0] model_mem [256];
  logic [7:0] ptr;

  eeprom_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .wc(wc), .sda_drive_low(dut_low)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] page_step(input logic [7:0] a, input int k);
    logic [3:0] lo;
    lo = a[3:0] + k[3:0];
    return {a[7:4], lo};
  endfunction

  function automatic logic [7:0] flat_step(input logic [7:0] a, input int k);
    return a + k[7:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wt(W);
    scl_m = 1'b1; wt(W);
    m_low = 1'b1; wt(W);
    scl_m = 1'b0; wt(W);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wt(W);
    scl_m = 1'b1; wt(W);
    m_low = 1'b0; wt(30);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wt(W);
      scl_m = 1'b1;  wt(W);
      scl_m = 1'b0;  wt(W);
    end
    m_low = 1'b0; wt(W);
    scl_m = 1'b1; wt(2);
    acked = ~sda_line;
    wt(W-2);
    scl_m = 1'b0; wt(W);
  endtask

  task automatic get_byte(input logic do_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wt(W);
      scl_m = 1'b1; wt(2);
      b[i] = sda_line;
      wt(W-2);
      scl_m = 1'b0; wt(W);
    end
    m_low = do_ack; wt(W);
    scl_m = 1'b1;   wt(W);
    scl_m = 1'b0;   wt(W);
    m_low = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input logic wcv);
    logic ack;
    logic [7:0] d;
    wc = wcv;
    bus_start();
    put_byte({DEV, 1'b0}, ack); chk("R2 select ack (write)", ack, 1);
    put_byte(a, ack);           chk("R3 address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      put_byte(d, ack);
      if (wcv) chk("R6 data nack under wc", ack, 0);
      else     chk("R4 data ack", ack, 1);
      if (!wcv) model_mem[page_step(a, i)] = d;
    end
    bus_stop();
    ptr = wcv ? a : page_step(a, n);
    wc = 1'b0;
  endtask

  task automatic read_run(input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, b);
      chk(tag, b, model_mem[ptr]);
      ptr = flat_step(ptr, 1);
    end
    bus_stop();
  endtask

  task automatic do_rand_read(input logic [7:0] a, input int n);
    logic ack;
    bus_start();
    put_byte({DEV, 1'b0}, ack); chk("R2 select ack", ack, 1);
    put_byte(a, ack);           chk("R3 address ack", ack, 1);
    bus_start();
    put_byte({DEV, 1'b1}, ack); chk("R8 read select ack", ack, 1);
    ptr = a;
    read_run(n, "R8/R9/R11 random-address read data");
  endtask

  task automatic do_cur_read(input int n);
    logic ack;
    bus_start();
    put_byte({DEV, 1'b1}, ack); chk("R7 read select ack", ack, 1);
    read_run(n, "R7/R11 current-address read data");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    logic [7:0] a;
    int n;
    n_cmp = 0; n_err = 0;
    void'($urandom(32'h5eed1234));
    scl_m = 1'b1; m_low = 1'b0; wc = 1'b0; rst_n = 1'b0; ptr = 8'h00;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    chk("R1 released after reset", dut_low, 0);
    chk("R1 line high after reset", sda_line, 1);

    // Fill the whole array with full pages
    for (int p = 0; p < 16; p++) do_write(8'(p * 16), 16, 1'b0);
    chk("R1 released after stop", dut_low, 0);

    // R9: run across the top of the array
    do_rand_read(8'hF8, 16);
    // R7: continue where the previous read ended
    do_cur_read(2);

    // R2: foreign select code, then garbage, then counter unchanged
    bus_start();
    put_byte(8'hA2, ack); chk("R2 foreign select nack", ack, 0);
    put_byte(8'h55, ack); chk("R2 ignored byte nack", ack, 0);
    bus_stop();
    do_cur_read(1);

    // R6: writes under wc leave memory unchanged
    do_write(8'h30, 3, 1'b1);
    do_rand_read(8'h30, 3);

    // R5: page wrap 0x4E,0x4F,0x40,0x41
    do_write(8'h4E, 4, 1'b0);
    chk("R5 pointer after page wrap", ptr, 8'h42);
    do_rand_read(8'h4E, 2);
    do_rand_read(8'h40, 3);

    // R4: single byte write
    do_write(8'h77, 1, 1'b0);
    do_rand_read(8'h77, 1);

    // R10: early NACK, then idle pulses, then counter advanced
    bus_start();
    put_byte({DEV, 1'b0}, ack);
    put_byte(8'h90, ack);
    bus_start();
    put_byte({DEV, 1'b1}, ack); chk("R8 read select ack", ack, 1);
    ptr = 8'h90;
    get_byte(1'b1, b); chk("R10 first byte", b, model_mem[ptr]); ptr = flat_step(ptr, 1);
    get_byte(1'b0, b); chk("R10 nacked byte", b, model_mem[ptr]); ptr = flat_step(ptr, 1);
    n = 0;
    for (int i = 0; i < 9; i++) begin
      wt(W); scl_m = 1'b1; wt(2);
      if (sda_line !== 1'b1) n++;
      wt(W-2); scl_m = 1'b0; wt(W);
    end
    chk("R10 slave silent after nack", n, 0);
    bus_stop();
    do_cur_read(1);

    // Constrained random mix
    for (int it = 0; it < 14; it++) begin
      a = 8'($urandom);
      n = 1 + int'($urandom % 5);
      case ($urandom % 3)
        0: do_write(a, n, 1'($urandom % 4 == 0));
        1: do_rand_read(a, n);
        default: do_cur_read(n);
      endcase
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule